// File: doc/BRIEF.md
# Wide Lane Multiply-Accumulator

This block holds a 192-bit signed accumulator that a packed-SIMD datapath uses for sums, differences and products of small integer elements. The accumulator is read as eight 24-bit lanes when the elements are bytes, and as four 48-bit lanes when the elements are halfwords. Each lane is three times as wide as the element that feeds it, so a long run of products can build up without loss. Every operation comes in two forms. One adds to the lane. The other overwrites the lane.

Each cycle the caller presents an opcode, a mode bit and two packed 64-bit operands. The operands already hold the per-lane values that the operand-select stage produced. Arithmetic and write operations update the accumulator on the clock edge. Read operations copy one third of every lane (low, middle or high) into a registered 64-bit output. Rounding and scaling of the accumulator contents belong to a later stage.

Top module: `wide_lane_mac`

## Requirements
- R1: A synchronous active-low reset clears the accumulator and the readback register to zero.
- R2: With `in_half`=0, element i is operand bits [8i+7:8i] and lane i is accumulator bits [24i+23:24i]. With `in_half`=1, element i is operand bits [16i+15:16i] and lane i is accumulator bits [48i+47:48i]. Both modes read the same stored bits, so the mode bit only changes how those bits are grouped into lanes.
- R3: Opcode 1 sets each lane to a+b. Opcode 0 adds a+b to the lane. Operands are sign-extended elements.
- R4: Opcode 3 sets each lane to a-b. Opcode 2 adds a-b to the lane.
- R5: The multiply opcodes use the signed product p=a*b. Opcode 4 adds p to the lane. Opcode 5 sets the lane to p. Opcode 6 subtracts p from the lane. Opcode 7 sets the lane to -p.
- R6: Lane arithmetic wraps modulo the lane width (24 or 48 bits). It does not saturate, and no carry passes into a neighbouring lane.
- R7: Opcodes 8, 9 and 10 copy lane bits [w-1:0], [2w-1:w] and [3w-1:2w] into element i of `out_rd`, where w is the element width. The copy appears after the clock edge of the read. The accumulator does not change. `out_rd` keeps its value for every other opcode.
- R8: Opcode 11 writes element a into the top third of each lane and keeps the lower two thirds.
- R9: Opcode 12 writes element a into the top third of each lane, and fills the lower two thirds with element b sign-extended to 2w bits.
- R10: While `in_valid` is low, neither the accumulator nor `out_rd` changes.
- R11: Opcodes 13 to 15 leave the accumulator and `out_rd` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation request strobe |
| in_op | input | 4 | Opcode (see R3 to R11) |
| in_half | input | 1 | 0: byte elements / 24-bit lanes, 1: halfword elements / 48-bit lanes |
| in_a | input | 64 | First packed operand |
| in_b | input | 64 | Second packed operand |
| out_rd | output | 64 | Registered readback of one third of every lane |

## Verification
Replicated operands chain every opcode through one lane value. The bench reads all three thirds after each step, so a wrong sign extension, a product that overflows into the wrong third, and a swapped load/accumulate form each give a different readback. Lanes loaded with their own index and then read in halfword mode show whether the two lane groupings overlay the same bits. Values placed just below the positive limit of a lane, in both modes, separate wrapping arithmetic from saturating arithmetic. Reserved opcodes and idle cycles come between known reads, so any change they cause shows up in `out_rd`.

// File: rtl/wlm_pkg.sv
// Shared opcode encoding and opcode classification for the wide-lane
// multiply-accumulator. Assumes a 4-bit opcode; values 13..15 are reserved.
package wlm_pkg;
    localparam logic [3:0] OP_ACC_ADD    = 4'd0;
    localparam logic [3:0] OP_LD_ADD     = 4'd1;
    localparam logic [3:0] OP_ACC_SUB    = 4'd2;
    localparam logic [3:0] OP_LD_SUB     = 4'd3;
    localparam logic [3:0] OP_MAC        = 4'd4;
    localparam logic [3:0] OP_MUL_LD     = 4'd5;
    localparam logic [3:0] OP_MSUB       = 4'd6;
    localparam logic [3:0] OP_NEG_MUL_LD = 4'd7;
    localparam logic [3:0] OP_RD_LO      = 4'd8;
    localparam logic [3:0] OP_RD_MID     = 4'd9;
    localparam logic [3:0] OP_RD_HI      = 4'd10;
    localparam logic [3:0] OP_WR_HI      = 4'd11;
    localparam logic [3:0] OP_WR_LO      = 4'd12;

    // True for the three readback opcodes.
    function automatic logic op_is_read(input logic [3:0] op);
        return (op == OP_RD_LO) || (op == OP_RD_MID) || (op == OP_RD_HI);
    endfunction

    // True for opcodes that rewrite the accumulator.
    function automatic logic op_is_update(input logic [3:0] op);
        return (op <= OP_NEG_MUL_LD) || (op == OP_WR_HI) || (op == OP_WR_LO);
    endfunction
endpackage

// File: rtl/wlm_lane.sv
// One accumulator lane: computes the next lane value and the selected
// readback third. Purely combinational. The lane is 3*EW bits wide and
// every sum wraps modulo that width. Operands are signed EW-bit elements.
module wlm_lane
    import wlm_pkg::*;
#(
    parameter int EW = 8
) (
    input  logic [3:0]      op,
    input  logic [EW-1:0]   a,
    input  logic [EW-1:0]   b,
    input  logic [3*EW-1:0] cur,
    output logic [3*EW-1:0] nxt,
    output logic [EW-1:0]   rd
);
    localparam int LW = 3 * EW;
    localparam int PW = 2 * EW;

    logic signed [EW-1:0] a_s;
    logic signed [EW-1:0] b_s;
    logic signed [PW-1:0] prod;
    logic [LW-1:0]        a_x;
    logic [LW-1:0]        b_x;
    logic [LW-1:0]        p_x;

    assign a_s  = a;
    assign b_s  = b;
    assign prod = a_s * b_s;
    assign a_x  = {{(LW-EW){a[EW-1]}}, a};
    assign b_x  = {{(LW-EW){b[EW-1]}}, b};
    assign p_x  = {{(LW-PW){prod[PW-1]}}, prod};

    // Next lane value for each opcode; reads and reserved codes keep it.
    always_comb begin
        case (op)
            OP_ACC_ADD:    nxt = cur + a_x + b_x;
            OP_LD_ADD:     nxt = a_x + b_x;
            OP_ACC_SUB:    nxt = cur + a_x - b_x;
            OP_LD_SUB:     nxt = a_x - b_x;
            OP_MAC:        nxt = cur + p_x;
            OP_MUL_LD:     nxt = p_x;
            OP_MSUB:       nxt = cur - p_x;
            OP_NEG_MUL_LD: nxt = '0 - p_x;
            OP_WR_HI:      nxt = {a, cur[PW-1:0]};
            OP_WR_LO:      nxt = {a, {EW{b[EW-1]}}, b};
            default:       nxt = cur;
        endcase
    end

    // Third of the lane selected by a readback opcode.
    always_comb begin
        case (op)
            OP_RD_LO:  rd = cur[EW-1:0];
            OP_RD_MID: rd = cur[PW-1:EW];
            OP_RD_HI:  rd = cur[LW-1:PW];
            default:   rd = '0;
        endcase
    end
endmodule

// File: rtl/wlm_bank.sv
// A full set of lanes for one element width. Splits packed operands and
// the accumulator into OPER_W/EW lanes and rejoins the results. Assumes
// EW divides OPER_W and that lane i sits at accumulator bits [3*EW*i +: 3*EW].
module wlm_bank #(
    parameter int OPER_W = 64,
    parameter int EW     = 8
) (
    input  logic [3:0]          op,
    input  logic [OPER_W-1:0]   a,
    input  logic [OPER_W-1:0]   b,
    input  logic [3*OPER_W-1:0] acc,
    output logic [3*OPER_W-1:0] acc_nxt,
    output logic [OPER_W-1:0]   rd
);
    localparam int NL = OPER_W / EW;
    localparam int LW = 3 * EW;

    for (genvar i = 0; i < NL; i++) begin : g_lane
        wlm_lane #(.EW(EW)) u_lane (
            .op  (op),
            .a   (a[i*EW +: EW]),
            .b   (b[i*EW +: EW]),
            .cur (acc[i*LW +: LW]),
            .nxt (acc_nxt[i*LW +: LW]),
            .rd  (rd[i*EW +: EW])
        );
    end
endmodule

// File: rtl/wlm_state.sv
// Accumulator and readback registers. Loads the accumulator on valid
// update opcodes and the readback on valid read opcodes. Synchronous
// active-low reset clears both.
module wlm_state
    import wlm_pkg::*;
#(
    parameter int OPER_W = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                valid,
    input  logic [3:0]          op,
    input  logic [3*OPER_W-1:0] acc_nxt,
    input  logic [OPER_W-1:0]   rd_nxt,
    output logic [3*OPER_W-1:0] acc_q,
    output logic [OPER_W-1:0]   rd_q
);
    // Accumulator register: reset, or take the lane results on an update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (valid && op_is_update(op)) begin
            acc_q <= acc_nxt;
        end
    end

    // Readback register: reset, or capture the selected thirds on a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (valid && op_is_read(op)) begin
            rd_q <= rd_nxt;
        end
    end
endmodule

// File: rtl/wide_lane_mac.sv
// Wide-lane multiply-accumulator top. Two lane banks (byte and halfword
// element width) work on the same accumulator bits. in_half picks which
// bank's results are stored and read back. Assumes OPER_W is a multiple
// of 2*ELEM_W.
module wide_lane_mac #(
    parameter int OPER_W = 64,
    parameter int ELEM_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        in_op,
    input  logic              in_half,
    input  logic [OPER_W-1:0] in_a,
    input  logic [OPER_W-1:0] in_b,
    output logic [OPER_W-1:0] out_rd
);
    localparam int ACC_W  = 3 * OPER_W;
    localparam int HALF_W = 2 * ELEM_W;

    logic [ACC_W-1:0]  acc_q;
    logic [ACC_W-1:0]  acc_b;
    logic [ACC_W-1:0]  acc_h;
    logic [ACC_W-1:0]  acc_nxt;
    logic [OPER_W-1:0] rd_b;
    logic [OPER_W-1:0] rd_h;
    logic [OPER_W-1:0] rd_nxt;

    wlm_bank #(.OPER_W(OPER_W), .EW(ELEM_W)) u_bank_byte (
        .op      (in_op),
        .a       (in_a),
        .b       (in_b),
        .acc     (acc_q),
        .acc_nxt (acc_b),
        .rd      (rd_b)
    );

    wlm_bank #(.OPER_W(OPER_W), .EW(HALF_W)) u_bank_half (
        .op      (in_op),
        .a       (in_a),
        .b       (in_b),
        .acc     (acc_q),
        .acc_nxt (acc_h),
        .rd      (rd_h)
    );

    // Choose the lane grouping given by the mode bit.
    always_comb begin
        acc_nxt = in_half ? acc_h : acc_b;
        rd_nxt  = in_half ? rd_h  : rd_b;
    end

    wlm_state #(.OPER_W(OPER_W)) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (in_valid),
        .op      (in_op),
        .acc_nxt (acc_nxt),
        .rd_nxt  (rd_nxt),
        .acc_q   (acc_q),
        .rd_q    (out_rd)
    );
endmodule

// File: rtl/wlm_checker.sv
// Temporal checks on the multiply-accumulator, bound into the top.
module wlm_checker
    import wlm_pkg::*;
#(
    parameter int OPER_W = 64,
    parameter int ELEM_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [3:0]          in_op,
    input logic                in_half,
    input logic [OPER_W-1:0]   in_a,
    input logic [OPER_W-1:0]   in_b,
    input logic [3*OPER_W-1:0] acc_q,
    input logic [OPER_W-1:0]   out_rd
);
    localparam int LW = 3 * ELEM_W;

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (acc_q == '0) && (out_rd == '0));

    p_load_add_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_LD_ADD && !in_half) |=>
        acc_q[LW-1:0] == $past({{(LW-ELEM_W){in_a[ELEM_W-1]}}, in_a[ELEM_W-1:0]}
                             + {{(LW-ELEM_W){in_b[ELEM_W-1]}}, in_b[ELEM_W-1:0]}));

    p_read_keeps_acc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_is_read(in_op)) |=> $stable(acc_q));

    p_rd_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !op_is_read(in_op)) |=> $stable(out_rd));

    p_write_hi_keeps_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_WR_HI && !in_half) |=>
        acc_q[2*ELEM_W-1:0] == $past(acc_q[2*ELEM_W-1:0]));

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(acc_q) && $stable(out_rd));

    p_reserved_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op > OP_WR_LO) |=> $stable(acc_q));
endmodule

bind wide_lane_mac wlm_checker #(.OPER_W(OPER_W), .ELEM_W(ELEM_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_op    (in_op),
    .in_half  (in_half),
    .in_a     (in_a),
    .in_b     (in_b),
    .acc_q    (acc_q),
    .out_rd   (out_rd)
);

// File: tb/sim_wide_lane_mac.sv
module sim_wide_lane_mac;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_op = 4'd0;
    logic        in_half = 1'b0;
    logic [63:0] in_a = '0;
    logic [63:0] in_b = '0;
    logic [63:0] out_rd;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wide_lane_mac u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_half(in_half), .in_a(in_a), .in_b(in_b), .out_rd(out_rd)
    );

    typedef struct packed {
        logic        v;
        logic [3:0]  op;
        logic        h;
        logic [63:0] a;
        logic [63:0] b;
        logic        c;
        logic [3:0]  rq;
        logic [63:0] e;
    } vec_t;

    localparam int N = 54;
    localparam vec_t TBL [N] = '{
        // R2 lane layout and mode overlay
        '{1'b1, 4'd1, 1'b0, 64'h0706050403020100, 64'h0, 1'b0, 4'd2, 64'h0},
        '{1'b1, 4'd8, 1'b0, 64'h0, 64'h0, 1'b1, 4'd2, 64'h0706050403020100},
        '{1'b1, 4'd9, 1'b0, 64'h0, 64'h0, 1'b1, 4'd2, 64'h0},
        '{1'b1, 4'd9, 1'b1, 64'h0, 64'h0, 1'b1, 4'd2, 64'h0700050003000100},
        // R3 add forms
        '{1'b1, 4'd1, 1'b0, {8{8'h05}}, {8{8'h03}}, 1'b0, 4'd3, 64'h0},
        '{1'b1, 4'd8, 1'b0, 64'h0, 64'h0, 1'b1, 4'd3, {8{8'h08}}},
        '{1'b1, 4'd0, 1'b0, {8{8'hFF}}, {8{8'hFE}}, 1'b0, 4'd3, 64'h0},
        '{1'b1, 4'd8, 1'b0, 64'h0, 64'h0, 1'b1, 4'd3, {8{8'h05}}},
        '{1'b1, 4'd10, 1'b0, 64'h0, 64'h0, 1'b1, 4'd3, 64'h0},
        // R4 difference forms
        '{1'b1, 4'd3, 1'b0, {8{8'h02}}, {8{8'h07}}, 1'b0, 4'd4, 64'h0},
        '{1'b1, 4'd8, 1'b0, 64'h0, 64'h0, 1'b1, 4'd4, {8{8'hFB}}},
        '{1'b1, 4'd10, 1'b0, 64'h0, 64'h0, 1'b1, 4'd4, {8{8'hFF}}},
        '{1'b1, 4'd2, 1'b0, {8{8'h00}}, {8{8'hF6}}, 1'b0, 4'd4, 64'h0},
        '{1'b1, 4'd8, 1'b0, 64'h0, 64'h0, 1'b1, 4'd4, {8{8'h05}}},
        // R5 multiply forms: 127*-128 = 0xFFC080
        '{1'b1, 4'd5, 1'b0, {8{8'h7F}}, {8{8'h80}}, 1'b0, 4'd5, 64'h0},
        '{1'b1, 4'd8, 1'b0, 64'h0, 64'h0, 1'b1, 4'd5, {8{8'h80}}},
        '{1'b1, 4'd9, 1'b0, 64'h0, 64'h0, 1'b1, 4'd5, {8{8'hC0}}},
        '{1'b1, 4'd10, 1'b0, 64'h0, 64'h0, 1'b1, 4'd5, {8{8'hFF}}},
        '{1'b1, 4'd4, 1'b0, {8{8'h10}}, {8{8'h10}}, 1'b0, 4'd5, 64'h0},
        '{1'b1, 4'd9, 1'b0, 64'h0, 64'h0, 1'b1, 4'd5, {8{8'hC1}}},
        '{1'b1, 4'd8, 1'b0, 64'h0, 64'h0, 1'b1, 4'd5, {8{8'h80}}},
        '{1'b1, 4'd6, 1'b0, {8{8'hFF}}, {8{8'h01}}, 1'b0, 4'd5, 64'h0},
        '{1'b1, 4'd8, 1'b0, 64'h0, 64'h0, 1'b1, 4'd5, {8{8'h81}}},
        '{1'b1, 4'd7, 1'b0, {8{8'h80}}, {8{8'h80}}, 1'b0, 4'd5, 64'h0},
        '{1'b1, 4'd9, 1'b0, 64'h0, 64'h0, 1'b1, 4'd5, {8{8'hC0}}},
        '{1'b1, 4'd8, 1'b0, 64'h0, 64'h0, 1'b1, 4'd5, 64'h0},
        // R8 write-high
        '{1'b1, 4'd11, 1'b0, {8{8'h12}}, 64'h0, 1'b0, 4'd8, 64'h0},
        '{1'b1, 4'd10, 1'b0, 64'h0, 64'h0, 1'b1, 4'd8, {8{8'h12}}},
        '{1'b1, 4'd9, 1'b0, 64'h0, 64'h0, 1'b1, 4'd8, {8{8'hC0}}},
        // R9 write-low with negative b
        '{1'b1, 4'd12, 1'b0, {8{8'h34}}, {8{8'h85}}, 1'b0, 4'd9, 64'h0},
        '{1'b1, 4'd10, 1'b0, 64'h0, 64'h0, 1'b1, 4'd9, {8{8'h34}}},
        '{1'b1, 4'd9, 1'b0, 64'h0, 64'h0, 1'b1, 4'd9, {8{8'hFF}}},
        '{1'b1, 4'd8, 1'b0, 64'h0, 64'h0, 1'b1, 4'd9, {8{8'h85}}},
        // R11 reserved opcodes
        '{1'b1, 4'd13, 1'b0, {8{8'hAA}}, {8{8'h55}}, 1'b0, 4'd11, 64'h0},
        '{1'b1, 4'd15, 1'b0, {8{8'hAA}}, {8{8'h55}}, 1'b0, 4'd11, 64'h0},
        '{1'b1, 4'd8, 1'b0, 64'h0, 64'h0, 1'b1, 4'd11, {8{8'h85}}},
        '{1'b1, 4'd10, 1'b0, 64'h0, 64'h0, 1'b1, 4'd11, {8{8'h34}}},
        // R10 idle cycles, R7 readback hold
        '{1'b0, 4'd1, 1'b0, {8{8'h11}}, {8{8'h22}}, 1'b0, 4'd10, 64'h0},
        '{1'b1, 4'd8, 1'b0, 64'h0, 64'h0, 1'b1, 4'd10, {8{8'h85}}},
        '{1'b0, 4'd10, 1'b0, 64'h0, 64'h0, 1'b1, 4'd10, {8{8'h85}}},
        '{1'b1, 4'd1, 1'b0, {8{8'h01}}, {8{8'h01}}, 1'b1, 4'd7, {8{8'h85}}},
        // R6 byte-mode wrap
        '{1'b1, 4'd12, 1'b0, {8{8'h7F}}, {8{8'hFF}}, 1'b0, 4'd6, 64'h0},
        '{1'b1, 4'd0, 1'b0, {8{8'h01}}, {8{8'h00}}, 1'b0, 4'd6, 64'h0},
        '{1'b1, 4'd10, 1'b0, 64'h0, 64'h0, 1'b1, 4'd6, {8{8'h80}}},
        '{1'b1, 4'd9, 1'b0, 64'h0, 64'h0, 1'b1, 4'd6, 64'h0},
        // Halfword mode: R3, R6, R5
        '{1'b1, 4'd1, 1'b1, {4{16'h1234}}, {4{16'h0001}}, 1'b0, 4'd3, 64'h0},
        '{1'b1, 4'd8, 1'b1, 64'h0, 64'h0, 1'b1, 4'd3, {4{16'h1235}}},
        '{1'b1, 4'd12, 1'b1, {4{16'h7FFF}}, {4{16'hFFFF}}, 1'b0, 4'd6, 64'h0},
        '{1'b1, 4'd0, 1'b1, {4{16'h0001}}, 64'h0, 1'b0, 4'd6, 64'h0},
        '{1'b1, 4'd10, 1'b1, 64'h0, 64'h0, 1'b1, 4'd6, {4{16'h8000}}},
        '{1'b1, 4'd9, 1'b1, 64'h0, 64'h0, 1'b1, 4'd6, 64'h0},
        '{1'b1, 4'd5, 1'b1, {4{16'h0100}}, {4{16'h0100}}, 1'b0, 4'd5, 64'h0},
        '{1'b1, 4'd9, 1'b1, 64'h0, 64'h0, 1'b1, 4'd5, {4{16'h0001}}},
        '{1'b1, 4'd8, 1'b1, 64'h0, 64'h0, 1'b1, 4'd5, 64'h0}
    };

    task automatic check(input string tag, input logic [63:0] exp);
        n_chk++;
        if (out_rd !== exp) begin
            n_fail++;
            $display("FAIL %s: out_rd=%h expected=%h", tag, out_rd, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [3:0] op, input logic h,
                         input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        in_valid = v; in_op = op; in_half = h; in_a = a; in_b = b;
        @(posedge clk);
        #2;
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset", 64'h0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b1, 4'd10, 1'b0, '0, '0);
        check("R1 byte high after reset", 64'h0);
        drive(1'b1, 4'd9, 1'b1, '0, '0);
        check("R1 half mid after reset", 64'h0);

        for (int k = 0; k < N; k++) begin
            drive(TBL[k].v, TBL[k].op, TBL[k].h, TBL[k].a, TBL[k].b);
            if (TBL[k].c) begin
                n_chk++;
                if (out_rd !== TBL[k].e) begin
                    n_fail++;
                    $display("FAIL R%0d vector %0d: out_rd=%h expected=%h",
                             TBL[k].rq, k, out_rd, TBL[k].e);
                end
            end
        end

        // R1 mid-run reset after non-zero state
        drive(1'b1, 4'd8, 1'b0, '0, '0);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        #2;
        check("R1 readback cleared", 64'h0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b1, 4'd10, 1'b1, '0, '0);
        check("R1 acc cleared", 64'h0);
        drive(1'b1, 4'd8, 1'b0, '0, '0);
        check("R1 acc cleared low", 64'h0);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule